// File: doc/BRIEF.md
# Twin-Quad Configurable Logic Cell

This block models one programmable logic cell. It has eight 4-input look-up tables that are split into two quads of four. It also holds nine storage elements and a fast carry path, so the same cell can act as random logic or as a nibble or byte adder.

Before the cell is used, the whole configuration is shifted in one bit per clock while a load strobe is high. The configuration sets:

- the contents of every table;
- the arithmetic mode;
- the data source of each register;
- whether set/reset sets or clears each register;
- per control group: clock polarity, clock-enable use, local set/reset use, and flop or latch behaviour;
- whether the global set/reset is honoured.

There are three control groups: one for each quad and one for the extra register. Each group has its own clock-enable and set/reset pin. The extra register can capture the top carry-out, which lets an adder be pipelined.

The user side is simple. Table inputs arrive as eight 4-bit nibbles, and direct register inputs are one bit per register. Results leave as eight function outputs, two carry-outs and nine register outputs.

Top module: `tqc_cell`

## Requirements
- R1: The configuration word is 179 bits wide and is shifted in most significant bit first, one bit per rising clock edge while `cfg_en` is high.
  - From the most significant bit down, the word holds: `gsr_off` (1 bit); `arith` (2 bits); three group controls, group 2 first; nine register controls, register 8 first; then eight 16-bit tables, table 7 first.
  - Each group control is {`clk_inv`, `ce_use`, `lsr_use`, `latch`}.
  - Each register control is {`src[1:0]`, `inv`, `sr_set`}.
  - `cfg_done` is 0 until exactly 179 bits have been taken and is 1 from then on.
  - After that the configuration ignores `cfg_en` until reset.
- R2: From reset until `cfg_done` is 1, every register output reads 0.
- R3: When `arith` is 0 (logic mode), `lut_f[i]` is bit `a` of table i, where `a` is `lut_in[4i+3:4i]`. In this mode `carry_out` is 0.
- R4: When `arith` is 2 or 3 (byte mode), the eight tables form one carry chain that starts from `carry_in[0]`. `carry_in[1]` is ignored.
  - Table i's output is the propagate term p. The carry into the next stage is the incoming carry when p is 1, and `lut_in[4i]` when p is 0.
  - `lut_f[i]` is p XOR the incoming carry.
  - `carry_out[1]` is the carry out of stage 7 and `carry_out[0]` is the carry out of stage 3.
  - With every table set to 16'h6666, this adds bit 0 and bit 1 of each nibble.
- R5: When `arith` is 1 (nibble mode), the upper quad starts its own chain from `carry_in[1]`. `carry_out[0]` and `carry_out[1]` are the carry-outs of the lower and upper quad.
- R6: The `src` field selects what a register loads: 0 = its table output, 1 = `din[r]` XOR `inv`, 2 = constant 0, 3 = constant 1. For register 8, a `src` of 0 means `carry_out[1]`.
- R7: A register's update follows a fixed priority:
  1. reset, or configuration not done, gives 0;
  2. global set/reset gives `sr_set`;
  3. local set/reset (when `lsr_use` is 1) gives `sr_set`;
  4. clock enable;
  5. data.

  A set/reset takes effect even when the clock enable is low.
- R8: With `gsr_off` set to 1, the `gsr` input has no effect on any register.
- R9: With `ce_use` at 1, a register holds its value while its group's `ce` is 0. With `ce_use` at 0, the `ce` pin is ignored.
- R10: With `clk_inv` at 1, the group's registers update on the falling edge of `clk` instead of the rising edge.
- R11: With `latch` at 1, the group's registers are transparent while the effective clock is high and hold while it is low.
- R12: Group controls are independent. Register r < 8 uses group r/4 and its `ce`/`lsr` pins; register 8 uses group 2. A group's `ce` and `lsr` pins never change the registers of another group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, also used for configuration shifting |
| rst | input | 1 | Synchronous active-high reset of configuration and registers |
| cfg_en | input | 1 | Shift strobe for configuration loading |
| cfg_din | input | 1 | Serial configuration bit, most significant first |
| cfg_done | output | 1 | High once the full configuration word is loaded |
| lut_in | input | 32 | Four address bits per table, table i at [4i+3:4i] |
| din | input | 9 | Direct data input for each register |
| carry_in | input | 2 | Chain carry-in; bit 1 feeds the upper quad in nibble mode |
| ce | input | 3 | Clock enable per control group |
| lsr | input | 3 | Local set/reset per control group |
| gsr | input | 1 | Global set/reset for the whole cell |
| lut_f | output | 8 | Table outputs, or sum bits in arithmetic modes |
| carry_out | output | 2 | Lower and upper chain carry-outs |
| reg_q | output | 9 | Register outputs, bit 8 is the extra register |

## Verification
The bench builds the cell with its package defaults: 4-input tables, eight tables in two quads, and three control groups, which gives a 179-bit configuration word. At that size every table can be swept through all sixteen addresses in one pass. The same size also lets a byte-wide add carry across the quad boundary, so the nibble and byte chain modes give visibly different sums for the same operands. Because the register controls are split into three groups, one configuration can load flops on both clock edges and a latch side by side. Priority and isolation between the groups can therefore be observed in a single run.

// File: rtl/tqc_pkg.sv
package tqc_pkg;

    localparam int LUT_K  = 4;
    localparam int N_LUT  = 8;
    localparam int N_QUAD = N_LUT / 2;
    localparam int N_REG  = N_LUT + 1;
    localparam int N_CTL  = 3;
    localparam int TBL_W  = 1 << LUT_K;
    localparam int IN_W   = N_LUT * LUT_K;

    typedef enum logic [1:0] {
        SRC_LUT = 2'd0,
        SRC_DIN = 2'd1,
        SRC_LO  = 2'd2,
        SRC_HI  = 2'd3
    } dsrc_e;

    typedef enum logic [1:0] {
        AR_LOGIC = 2'd0,
        AR_NIB   = 2'd1,
        AR_BYTE  = 2'd2,
        AR_BYTE2 = 2'd3
    } arith_e;

    typedef struct packed {
        logic clk_inv;
        logic ce_use;
        logic lsr_use;
        logic latch;
    } grp_ctl_t;

    typedef struct packed {
        dsrc_e src;
        logic  inv;
        logic  sr_set;
    } reg_cfg_t;

    typedef struct packed {
        logic                              gsr_off;
        arith_e                            arith;
        grp_ctl_t [N_CTL-1:0]              ctl;
        reg_cfg_t [N_REG-1:0]              rcfg;
        logic     [N_LUT-1:0][TBL_W-1:0]   tbl;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    function automatic logic chain_on(arith_e m);
        return m != AR_LOGIC;
    endfunction

endpackage

// File: rtl/tqc_cfg_chain.sv
module tqc_cfg_chain #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         shift_bit,
    output logic [W-1:0] vec,
    output logic         done
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(W));

    always_ff @(posedge clk) begin
        if (rst) begin
            vec <= '0;
            cnt <= '0;
        end else if (shift_en && !done) begin
            vec <= {vec[W-2:0], shift_bit};
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tqc_lut_arith.sv
module tqc_lut_arith
    import tqc_pkg::*;
(
    input  logic [IN_W-1:0]               lut_in,
    input  logic [N_LUT-1:0][TBL_W-1:0]   tbl,
    input  arith_e                        arith,
    input  logic [1:0]                    carry_in,
    output logic [N_LUT-1:0]              lut_f,
    output logic [1:0]                    carry_out
);
    logic [N_LUT-1:0] f_raw;
    logic [N_LUT-1:0] gen_bit;
    logic [N_LUT-1:0] sum;
    logic             c_mid;
    logic             c_top;

    for (genvar i = 0; i < N_LUT; i++) begin : g_lut
        logic [LUT_K-1:0] addr;
        assign addr       = lut_in[i*LUT_K +: LUT_K];
        assign f_raw[i]   = tbl[i][addr];
        assign gen_bit[i] = addr[0];
    end

    always_comb begin
        logic c;
        c     = carry_in[0];
        c_mid = 1'b0;
        for (int i = 0; i < N_LUT; i++) begin
            if (i == N_QUAD && arith == AR_NIB) c = carry_in[1];
            sum[i] = f_raw[i] ^ c;
            c      = f_raw[i] ? c : gen_bit[i];
            if (i == N_QUAD - 1) c_mid = c;
        end
        c_top = c;
    end

    assign lut_f     = chain_on(arith) ? sum : f_raw;
    assign carry_out = chain_on(arith) ? {c_top, c_mid} : 2'b00;
endmodule

// File: rtl/tqc_cell_reg.sv
module tqc_cell_reg
    import tqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_done,
    input  grp_ctl_t ctl,
    input  reg_cfg_t rc,
    input  logic     gsr_off,
    input  logic     lut_bit,
    input  logic     din_bit,
    input  logic     ce,
    input  logic     lsr,
    input  logic     gsr,
    output logic     q
);
    logic eclk;
    logic d_sel;
    logic clear;
    logic sr_hit;
    logic load;
    logic nxt;
    logic q_ff;
    logic q_lat;

    assign eclk = clk ^ ctl.clk_inv;

    always_comb begin
        unique case (rc.src)
            SRC_LUT: d_sel = lut_bit;
            SRC_DIN: d_sel = din_bit ^ rc.inv;
            SRC_LO:  d_sel = 1'b0;
            default: d_sel = 1'b1;
        endcase
    end

    assign clear  = rst | ~cfg_done;
    assign sr_hit = (gsr & ~gsr_off) | (lsr & ctl.lsr_use);
    assign load   = clear | sr_hit | ~ctl.ce_use | ce;
    assign nxt    = clear ? 1'b0 : (sr_hit ? rc.sr_set : d_sel);

    always_ff @(posedge eclk) begin
        if (load) q_ff <= nxt;
    end

    always_latch begin
        if (eclk && load) q_lat = nxt;
    end

    assign q = ctl.latch ? q_lat : q_ff;
endmodule

// File: rtl/tqc_cell.sv
module tqc_cell
    import tqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_din,
    output logic              cfg_done,
    input  logic [IN_W-1:0]   lut_in,
    input  logic [N_REG-1:0]  din,
    input  logic [1:0]        carry_in,
    input  logic [N_CTL-1:0]  ce,
    input  logic [N_CTL-1:0]  lsr,
    input  logic              gsr,
    output logic [N_LUT-1:0]  lut_f,
    output logic [1:0]        carry_out,
    output logic [N_REG-1:0]  reg_q
);
    logic [CFG_W-1:0] cfg_vec;
    cell_cfg_t        cfg;

    tqc_cfg_chain #(.W(CFG_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (cfg_en),
        .shift_bit (cfg_din),
        .vec       (cfg_vec),
        .done      (cfg_done)
    );

    assign cfg = cell_cfg_t'(cfg_vec);

    tqc_lut_arith u_lut (
        .lut_in    (lut_in),
        .tbl       (cfg.tbl),
        .arith     (cfg.arith),
        .carry_in  (carry_in),
        .lut_f     (lut_f),
        .carry_out (carry_out)
    );

    for (genvar r = 0; r < N_REG; r++) begin : g_reg
        localparam int CI = (r < N_LUT) ? (r / N_QUAD) : (N_CTL - 1);
        logic src_bit;
        if (r < N_LUT) begin : g_tbl
            assign src_bit = lut_f[r];
        end else begin : g_cry
            assign src_bit = carry_out[1];
        end
        tqc_cell_reg u_reg (
            .clk      (clk),
            .rst      (rst),
            .cfg_done (cfg_done),
            .ctl      (cfg.ctl[CI]),
            .rc       (cfg.rcfg[r]),
            .gsr_off  (cfg.gsr_off),
            .lut_bit  (src_bit),
            .din_bit  (din[r]),
            .ce       (ce[CI]),
            .lsr      (lsr[CI]),
            .gsr      (gsr),
            .q        (reg_q[r])
        );
    end
endmodule

// File: rtl/tqc_cell_chk.sv
module tqc_cell_chk
    import tqc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_done,
    input cell_cfg_t        cfg,
    input logic [N_CTL-1:0] lsr,
    input logic [N_REG-1:0] reg_q
);
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> cfg_done);                                        // R1

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> $stable(cfg));                                    // R1

    AST_UNCONFIG_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cfg_done |-> reg_q == '0);                                    // R2

    AST_CONST_LO_STAYS: assert property (@(posedge clk) disable iff (rst)
        (cfg_done && cfg.rcfg[2].src == SRC_LO && !cfg.rcfg[2].sr_set)
        |-> !reg_q[2]);                                                // R6

    AST_LSR_WINS: assert property (@(posedge clk) disable iff (rst)
        (cfg_done && $past(cfg_done) && !$past(rst) && $past(lsr[0]) &&
         cfg.ctl[0].lsr_use && !cfg.ctl[0].clk_inv && !cfg.ctl[0].latch)
        |-> reg_q[0] == cfg.rcfg[0].sr_set);                           // R7
endmodule

bind tqc_cell tqc_cell_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_done (cfg_done),
    .cfg      (cfg),
    .lsr      (lsr),
    .reg_q    (reg_q)
);

// File: tb/tqc_cell_bench.sv
`timescale 1ns/100ps
module tqc_cell_bench;
    import tqc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_en = 1'b0;
    logic              cfg_din = 1'b0;
    logic              cfg_done;
    logic [IN_W-1:0]   lut_in = '0;
    logic [N_REG-1:0]  din = '0;
    logic [1:0]        carry_in = '0;
    logic [N_CTL-1:0]  ce = '1;
    logic [N_CTL-1:0]  lsr = '0;
    logic              gsr = 1'b0;
    logic [N_LUT-1:0]  lut_f;
    logic [1:0]        carry_out;
    logic [N_REG-1:0]  reg_q;

    int n_cmp = 0;
    int n_mis = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    tqc_cell u_tqc_cell (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .cfg_done(cfg_done), .lut_in(lut_in), .din(din),
        .carry_in(carry_in), .ce(ce), .lsr(lsr), .gsr(gsr),
        .lut_f(lut_f), .carry_out(carry_out), .reg_q(reg_q)
    );

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic       cin;
        logic [8:0] sum;
    } add_vec_t;

    localparam add_vec_t ADD_VEC [8] = '{
        '{8'h00, 8'h00, 1'b0, 9'h000},
        '{8'hFF, 8'h01, 1'b0, 9'h100},
        '{8'hFF, 8'hFF, 1'b1, 9'h1FF},
        '{8'h5A, 8'hA5, 1'b0, 9'h0FF},
        '{8'h5A, 8'hA5, 1'b1, 9'h100},
        '{8'h80, 8'h80, 1'b0, 9'h100},
        '{8'h0F, 8'h01, 1'b0, 9'h010},
        '{8'h3C, 8'h29, 1'b1, 9'h066}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; cfg_en = 1'b0; gsr = 1'b0; lsr = '0; ce = '1;
        din = '0; lut_in = '0; carry_in = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic load_cfg(input cell_cfg_t c);
        for (int i = CFG_W - 1; i >= 0; i--) begin
            cfg_en  = 1'b1;
            cfg_din = c[i];
            if (i == 0) chk("R1 done low before last bit", 32'(cfg_done), 32'd0);
            if (i == CFG_W / 2) chk("R2 registers zero while loading", 32'(reg_q), 32'd0);
            step();
        end
        cfg_en = 1'b0;
        chk("R1 done after full word", 32'(cfg_done), 32'd1);
    endtask

    function automatic logic [IN_W-1:0] pack_ops(input logic [7:0] a, input logic [7:0] b);
        logic [IN_W-1:0] r;
        r = '0;
        for (int i = 0; i < N_LUT; i++) begin
            r[i*LUT_K]     = a[i];
            r[i*LUT_K + 1] = b[i];
        end
        return r;
    endfunction

    function automatic logic [N_LUT-1:0] lut_ref(input cell_cfg_t c, input logic [IN_W-1:0] in);
        logic [N_LUT-1:0] r;
        for (int i = 0; i < N_LUT; i++) r[i] = c.tbl[i][in[i*LUT_K +: LUT_K]];
        return r;
    endfunction

    initial begin
        #(5.0 * 150000);
        n_cmp++;
        n_mis++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        cell_cfg_t cl;
        cell_cfg_t ca;
        cell_cfg_t cb;

        // Reset state, R2 and R1
        do_reset();
        chk("R2 reset register outputs", 32'(reg_q), 32'd0);
        chk("R1 done low after reset", 32'(cfg_done), 32'd0);

        // Logic mode, random tables: R3
        cl = '0;
        cl.arith = AR_LOGIC;
        for (int i = 0; i < N_LUT; i++) cl.tbl[i] = 16'($urandom);
        load_cfg(cl);
        for (int a = 0; a < TBL_W; a++) begin
            lut_in = {N_LUT{4'(a)}};
            #1;
            chk("R3 address sweep", 32'(lut_f), 32'(lut_ref(cl, lut_in)));
        end
        for (int k = 0; k < 20; k++) begin
            lut_in = IN_W'($urandom);
            #1;
            chk("R3 random address", 32'(lut_f), 32'(lut_ref(cl, lut_in)));
            chk("R3 no carry in logic mode", 32'(carry_out), 32'd0);
        end
        // R1: word frozen once loaded
        for (int k = 0; k < 10; k++) begin
            cfg_en = 1'b1; cfg_din = 1'($urandom); step();
        end
        cfg_en = 1'b0;
        lut_in = 32'h9C5A_3E71;
        #1;
        chk("R1 tables unchanged after extra shifts", 32'(lut_f), 32'(lut_ref(cl, lut_in)));

        // Byte adder table walk: R4, ninth register capture R6
        do_reset();
        ca = '0;
        ca.arith = AR_BYTE;
        for (int i = 0; i < N_LUT; i++) ca.tbl[i] = 16'h6666;
        load_cfg(ca);
        for (int v = 0; v < 8; v++) begin
            lut_in   = pack_ops(ADD_VEC[v].a, ADD_VEC[v].b);
            carry_in = {1'b1, ADD_VEC[v].cin};
            #1;
            chk("R4 byte sum table", 32'({carry_out[1], lut_f}), 32'(ADD_VEC[v].sum));
            chk("R4 byte sum integer", 32'({carry_out[1], lut_f}),
                32'(ADD_VEC[v].a) + 32'(ADD_VEC[v].b) + 32'(ADD_VEC[v].cin));
            step();
            chk("R6 registers capture sum and carry", 32'(reg_q), 32'(ADD_VEC[v].sum));
        end
        lut_in = pack_ops(8'h3F, 8'h41); carry_in = 2'b10;
        #1;
        chk("R4 byte ignores upper carry_in", 32'(lut_f), 32'h80);
        chk("R4 byte carry outs", 32'(carry_out), 32'h1);

        // Nibble mode: R5
        do_reset();
        ca.arith = AR_NIB;
        load_cfg(ca);
        lut_in = pack_ops(8'h3F, 8'h41); carry_in = 2'b00;
        #1;
        chk("R5 nibble split sum", 32'(lut_f), 32'h70);
        chk("R5 nibble carry outs", 32'(carry_out), 32'h1);
        carry_in = 2'b10;
        #1;
        chk("R5 upper chain carry_in", 32'(lut_f), 32'h80);

        // Register controls
        do_reset();
        cb = '0;
        cb.arith = AR_LOGIC;
        cb.tbl[0] = 16'hAAAA;
        cb.ctl[0] = '{clk_inv: 1'b0, ce_use: 1'b1, lsr_use: 1'b1, latch: 1'b0};
        cb.ctl[1] = '{clk_inv: 1'b1, ce_use: 1'b0, lsr_use: 1'b0, latch: 1'b0};
        cb.ctl[2] = '{clk_inv: 1'b0, ce_use: 1'b0, lsr_use: 1'b0, latch: 1'b1};
        cb.rcfg[0] = '{src: SRC_LUT, inv: 1'b0, sr_set: 1'b1};
        cb.rcfg[1] = '{src: SRC_DIN, inv: 1'b1, sr_set: 1'b0};
        cb.rcfg[2] = '{src: SRC_LO,  inv: 1'b0, sr_set: 1'b0};
        cb.rcfg[3] = '{src: SRC_HI,  inv: 1'b0, sr_set: 1'b0};
        cb.rcfg[4] = '{src: SRC_DIN, inv: 1'b0, sr_set: 1'b0};
        cb.rcfg[5] = '{src: SRC_HI,  inv: 1'b0, sr_set: 1'b0};
        cb.rcfg[6] = '{src: SRC_HI,  inv: 1'b0, sr_set: 1'b0};
        cb.rcfg[7] = '{src: SRC_HI,  inv: 1'b0, sr_set: 1'b0};
        cb.rcfg[8] = '{src: SRC_DIN, inv: 1'b0, sr_set: 1'b0};
        load_cfg(cb);
        step();
        chk("R6 source selection", 32'(reg_q), 32'h0EA);
        lut_in[0] = 1'b1; step();
        chk("R6 table source", 32'(reg_q[0]), 32'd1);
        ce[0] = 1'b0; lut_in[0] = 1'b0; step();
        chk("R9 hold while ce low", 32'(reg_q[0]), 32'd1);
        ce[1] = 1'b0; din[4] = 1'b1; step();
        chk("R9 ce ignored when unused", 32'(reg_q[4]), 32'd1);
        ce[0] = 1'b1; step();
        chk("R9 loads when ce high", 32'(reg_q[0]), 32'd0);
        ce[0] = 1'b0; lsr[0] = 1'b1; step();
        chk("R7 lsr sets over ce", 32'(reg_q[0]), 32'd1);
        chk("R7 lsr clears", 32'(reg_q[3:1]), 32'd0);
        chk("R12 other quad untouched", 32'(reg_q[7:4]), 32'hF);
        lsr[0] = 1'b0; ce[0] = 1'b1; step();
        chk("R7 data after lsr release", 32'(reg_q[3:0]), 32'hA);
        gsr = 1'b1; step();
        chk("R7 global set/reset", 32'(reg_q), 32'h001);
        gsr = 1'b0; step(); step();
        chk("R10 falling-edge register reloaded", 32'(reg_q[4]), 32'd1);
        din[4] = 1'b0;
        #1;
        chk("R10 no update before falling edge", 32'(reg_q[4]), 32'd1);
        #2;
        chk("R10 update after falling edge", 32'(reg_q[4]), 32'd0);
        step();
        din[8] = 1'b1;
        #0.5;
        chk("R11 latch transparent while high", 32'(reg_q[8]), 32'd1);
        #1.5;
        din[8] = 1'b0;
        #0.5;
        chk("R11 latch holds while low", 32'(reg_q[8]), 32'd1);
        step();
        chk("R11 latch follows next high phase", 32'(reg_q[8]), 32'd0);

        // Global set/reset disabled: R8
        do_reset();
        cb.gsr_off = 1'b1;
        load_cfg(cb);
        step();
        gsr = 1'b1; step(); step();
        chk("R8 disabled global set/reset", 32'(reg_q), 32'h0EA);
        gsr = 1'b0;

        finish_run();
    end
endmodule